// File: doc/BRIEF.md
# Sequenced Control Register Access Port

This block is the processor-facing register port of a programmable serial communications controller. A host reaches the controller's registers through a chip select, a two-bit address, a direction input and an eight-bit data path. The block decodes each access and keeps the configuration registers: two mode registers, a command register, and three synchronisation-character registers (first sync, second sync and the link-escape character). It returns the receive holding byte and a status byte that come from the serial datapath. It also presents the transmit holding byte to that datapath.

Several registers share one address. Two self-advancing pointers select among them. The mode pointer alternates between the first and second mode register on every completed mode access, whether that access is a read or a write. The sync pointer walks first sync, then second sync, then escape on each write to the sync address, and after the last one it returns to the first. An access takes effect only when chip select deasserts, so an access held for many cycles still counts once. Reset clears both pointers, and so does a completed read of the command register. The data bus is modelled as separate in and out vectors plus an output enable that a pad ring turns into a tri-state bus.

Top module: `ctl_reg_port`

## Requirements
- R1: While `cs_n` is high, `dout_en` is 0 (the bus is released).
- R2: While `cs_n` is low and `wr_rd` is 0 (read), `dout_en` is 1. In the same cycle `dout` shows the selected register: address 0 gives `rx_hold_in`, address 1 the status byte, address 2 the mode register under the mode pointer, and address 3 the command register.
- R3: A write to address 0 loads `tx_hold`, and a write to address 3 loads `cmd_reg`. Either load uses the `din` value seen in the last cycle with `cs_n` low, and it is visible in the cycle after `cs_n` returns high.
- R4: Completed accesses to address 2, reads and writes alike, use the mode pointer `mr_ptr` (0 = first mode register, bits 7:0 of `mode_regs`; 1 = second, bits 15:8). The pointer starts at 0 and toggles after every such access. A write stores into the pointed register.
- R5: A completed write to address 1 stores into the register under `syn_ptr` (0 = first sync, bits 7:0 of `sync_regs`; 1 = second sync, bits 15:8; 2 = escape, bits 23:16). The pointer then advances 0, 1, 2 and back to 0. It never holds 3. Reads of address 1 leave it unchanged.
- R6: A completed read of address 3 returns both pointers to 0. No other access, including a write to address 3, moves a pointer in a way that R4 and R5 do not describe.
- R7: While `rst_n` is low at a clock edge, both pointers and every stored register (mode, command, sync, transmit holding, status) become 0.
- R8: The status byte read at address 1 is `status_in` as sampled at the previous clock edge.
- R9: A pointer moves only on the edge where `cs_n` is seen high after an access. An access that holds `cs_n` low for several cycles advances it exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; an access ends when it rises |
| addr | input | 2 | Register address |
| wr_rd | input | 1 | Direction: 1 = write, 0 = read |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data toward the host |
| dout_en | output | 1 | Bus drive enable for the tri-state pad |
| rx_hold_in | input | 8 | Receive holding byte from the serial datapath |
| status_in | input | 8 | Status byte from the serial datapath |
| tx_hold | output | 8 | Transmit holding byte toward the serial datapath |
| cmd_reg | output | 8 | Command register contents |
| mode_regs | output | 16 | Mode registers, first in bits 7:0 |
| sync_regs | output | 24 | First sync, second sync, escape, from low byte upward |
| mr_ptr | output | 1 | Mode pointer (debug) |
| syn_ptr | output | 2 | Sync pointer (debug) |

## Verification
A pointer that slips or double-steps appears on `mr_ptr` or `syn_ptr` in the first cycle after the access that caused it. It also shows on the next mode read, which puts the wrong byte on `dout`, and on the next sync write, which lands in the wrong byte of `sync_regs`. A wrong decode shows on `dout`, or on a register output in the cycle after chip select rises. The bench compares every port against a behavioural model on every clock, so any such fault is seen within one cycle of its cause.

// File: rtl/cpa_pkg.sv
// Shared types for the sequenced control register access port.
// Assumes a two-bit address and a single direction bit (1 = write).
package cpa_pkg;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_RX_RD,
        ACC_TX_WR,
        ACC_STS_RD,
        ACC_SYN_WR,
        ACC_MR_RD,
        ACC_MR_WR,
        ACC_CMD_RD,
        ACC_CMD_WR
    } acc_kind_e;

    // Map address and direction onto an access kind.
    function automatic acc_kind_e decode_access(input logic [1:0] a, input logic wr);
        acc_kind_e k;
        unique case (a)
            2'd0:    k = wr ? ACC_TX_WR  : ACC_RX_RD;
            2'd1:    k = wr ? ACC_SYN_WR : ACC_STS_RD;
            2'd2:    k = wr ? ACC_MR_WR  : ACC_MR_RD;
            default: k = wr ? ACC_CMD_WR : ACC_CMD_RD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cpa_access_track.sv
// Access tracker: records the kind and data of an access while chip select
// is low and produces a one-cycle completion pulse on the first edge where
// chip select is seen high again. Assumes inputs are synchronous to clk.
module cpa_access_track
    import cpa_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic [1:0]    addr,
    input  logic          wr_rd,
    input  logic [DW-1:0] din,
    output logic          done,
    output acc_kind_e     done_kind,
    output logic [DW-1:0] done_data,
    output acc_kind_e     live_kind
);

    logic          act_q;
    acc_kind_e     kind_q;
    logic [DW-1:0] data_q;

    // Capture the latest address, direction and data while the access is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            kind_q <= ACC_NONE;
            data_q <= '0;
        end else if (!cs_n) begin
            act_q  <= 1'b1;
            kind_q <= decode_access(addr, wr_rd);
            data_q <= din;
        end else begin
            act_q  <= 1'b0;
        end
    end

    // Completion is the first cycle with chip select high after an access.
    always_comb begin
        done      = act_q & cs_n;
        done_kind = kind_q;
        done_data = data_q;
    end

    // Decode of the access in progress, used by the read path.
    always_comb begin
        live_kind = cs_n ? ACC_NONE : decode_access(addr, wr_rd);
    end

endmodule

// File: rtl/cpa_wrap_ctr.sv
// Wrapping index counter: steps 0..N-1 and back to 0, with a clear that
// takes priority. Assumes N >= 2.
module cpa_wrap_ctr #(
    parameter int N = 3,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] LAST = W'(N - 1);

    // Advance or clear the index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cpa_reg_bank.sv
// Register storage and read multiplexer. Writes land on a completion pulse,
// indexed by the pointers; reads are combinational from the live decode.
// Assumes the pointers never exceed their register counts.
module cpa_reg_bank
    import cpa_pkg::*;
#(
    parameter int DW    = 8,
    parameter int MR_N  = 2,
    parameter int SYN_N = 3,
    localparam int MRW  = (MR_N > 1) ? $clog2(MR_N) : 1,
    localparam int SW   = (SYN_N > 1) ? $clog2(SYN_N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  acc_kind_e          done_kind,
    input  logic [DW-1:0]      done_data,
    input  acc_kind_e          live_kind,
    input  logic [MRW-1:0]     mr_ptr,
    input  logic [SW-1:0]      syn_ptr,
    input  logic [DW-1:0]      rx_hold_in,
    input  logic [DW-1:0]      status_in,
    output logic [DW-1:0]      tx_hold,
    output logic [DW-1:0]      cmd_reg,
    output logic [MR_N*DW-1:0] mode_regs,
    output logic [SYN_N*DW-1:0] sync_regs,
    output logic [DW-1:0]      dout
);

    logic [DW-1:0] mode_q [MR_N];
    logic [DW-1:0] syn_q  [SYN_N];
    logic [DW-1:0] sts_q;
    logic [DW-1:0] mode_sel;

    // Single-address registers: transmit holding, command, sampled status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            cmd_reg <= '0;
            sts_q   <= '0;
        end else begin
            sts_q <= status_in;
            if (done && done_kind == ACC_TX_WR)  tx_hold <= done_data;
            if (done && done_kind == ACC_CMD_WR) cmd_reg <= done_data;
        end
    end

    for (genvar g = 0; g < MR_N; g++) begin : g_mode
        // Mode register g loads when the mode pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[g] <= '0;
            end else if (done && done_kind == ACC_MR_WR && mr_ptr == MRW'(g)) begin
                mode_q[g] <= done_data;
            end
        end
        assign mode_regs[g*DW +: DW] = mode_q[g];
    end

    for (genvar g = 0; g < SYN_N; g++) begin : g_sync
        // Sync register g loads when the sync pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                syn_q[g] <= '0;
            end else if (done && done_kind == ACC_SYN_WR && syn_ptr == SW'(g)) begin
                syn_q[g] <= done_data;
            end
        end
        assign sync_regs[g*DW +: DW] = syn_q[g];
    end

    // Pick the mode register under the pointer.
    always_comb begin
        mode_sel = '0;
        for (int i = 0; i < MR_N; i++) begin
            if (mr_ptr == MRW'(i)) mode_sel = mode_q[i];
        end
    end

    // Read data multiplexer driven by the access in progress.
    always_comb begin
        unique case (live_kind)
            ACC_RX_RD:  dout = rx_hold_in;
            ACC_STS_RD: dout = sts_q;
            ACC_MR_RD:  dout = mode_sel;
            ACC_CMD_RD: dout = cmd_reg;
            default:    dout = '0;
        endcase
    end

endmodule

// File: rtl/ctl_reg_port.sv
// Top of the sequenced control register access port: access tracking,
// the two shared-address pointers, register storage and bus enable.
// Assumes a synchronous host interface and synchronous active-low reset.
module ctl_reg_port
    import cpa_pkg::*;
#(
    parameter int DW    = 8,
    parameter int MR_N  = 2,
    parameter int SYN_N = 3,
    localparam int MRW  = (MR_N > 1) ? $clog2(MR_N) : 1,
    localparam int SW   = (SYN_N > 1) ? $clog2(SYN_N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic [1:0]          addr,
    input  logic                wr_rd,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       dout,
    output logic                dout_en,
    input  logic [DW-1:0]       rx_hold_in,
    input  logic [DW-1:0]       status_in,
    output logic [DW-1:0]       tx_hold,
    output logic [DW-1:0]       cmd_reg,
    output logic [MR_N*DW-1:0]  mode_regs,
    output logic [SYN_N*DW-1:0] sync_regs,
    output logic [MRW-1:0]      mr_ptr,
    output logic [SW-1:0]       syn_ptr
);

    logic          done;
    acc_kind_e     done_kind;
    logic [DW-1:0] done_data;
    acc_kind_e     live_kind;
    logic          mr_step;
    logic          syn_step;
    logic          ptr_clr;

    cpa_access_track #(.DW(DW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .wr_rd     (wr_rd),
        .din       (din),
        .done      (done),
        .done_kind (done_kind),
        .done_data (done_data),
        .live_kind (live_kind)
    );

    // Pointer control from the completed access.
    always_comb begin
        mr_step  = done && (done_kind == ACC_MR_RD || done_kind == ACC_MR_WR);
        syn_step = done && (done_kind == ACC_SYN_WR);
        ptr_clr  = done && (done_kind == ACC_CMD_RD);
    end

    cpa_wrap_ctr #(.N(MR_N)) u_mr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .step  (mr_step),
        .cnt   (mr_ptr)
    );

    cpa_wrap_ctr #(.N(SYN_N)) u_syn_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .step  (syn_step),
        .cnt   (syn_ptr)
    );

    cpa_reg_bank #(.DW(DW), .MR_N(MR_N), .SYN_N(SYN_N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .done_kind  (done_kind),
        .done_data  (done_data),
        .live_kind  (live_kind),
        .mr_ptr     (mr_ptr),
        .syn_ptr    (syn_ptr),
        .rx_hold_in (rx_hold_in),
        .status_in  (status_in),
        .tx_hold    (tx_hold),
        .cmd_reg    (cmd_reg),
        .mode_regs  (mode_regs),
        .sync_regs  (sync_regs),
        .dout       (dout)
    );

    // Drive the bus only during a read with chip select low.
    always_comb begin
        dout_en = !cs_n && !wr_rd;
    end

endmodule

// File: rtl/cpa_checker.sv
// Protocol checker for ctl_reg_port, attached by bind. Observes ports only.
module cpa_checker #(
    parameter int DW    = 8,
    parameter int MR_N  = 2,
    parameter int SYN_N = 3,
    localparam int MRW  = (MR_N > 1) ? $clog2(MR_N) : 1,
    localparam int SW   = (SYN_N > 1) ? $clog2(SYN_N) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                wr_rd,
    input logic                dout_en,
    input logic [DW-1:0]       cmd_reg,
    input logic [MR_N*DW-1:0]  mode_regs,
    input logic [MRW-1:0]      mr_ptr,
    input logic [SW-1:0]       syn_ptr
);

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !dout_en); // R1
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && !wr_rd) |-> dout_en); // R2
    AST_SYN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) syn_ptr < SW'(SYN_N)); // R5
    AST_SYN_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n) (syn_ptr != $past(syn_ptr) && syn_ptr != '0) |-> syn_ptr == $past(syn_ptr) + 1'b1); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (mr_ptr == '0 && syn_ptr == '0 && cmd_reg == '0 && mode_regs == '0)); // R7
    AST_PTR_HOLD_MID_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |=> ($stable(mr_ptr) && $stable(syn_ptr))); // R9

endmodule

bind ctl_reg_port cpa_checker #(.DW(DW), .MR_N(MR_N), .SYN_N(SYN_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_rd     (wr_rd),
    .dout_en   (dout_en),
    .cmd_reg   (cmd_reg),
    .mode_regs (mode_regs),
    .mr_ptr    (mr_ptr),
    .syn_ptr   (syn_ptr)
);

// File: tb/sim_ctl_reg_port.sv
// Bench for ctl_reg_port: a behavioural model updated on each rising edge,
// compared with every output shortly after each falling edge.
module sim_ctl_reg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [1:0]  addr = '0;
    logic        wr_rd = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic [7:0]  rx_hold_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  tx_hold;
    logic [7:0]  cmd_reg;
    logic [15:0] mode_regs;
    logic [23:0] sync_regs;
    logic        mr_ptr;
    logic [1:0]  syn_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 0;
    bit ended = 0;

    // Model state.
    int         mptr = 0, sptr = 0;
    logic [7:0] m_mode [2];
    logic [7:0] m_syn [3];
    logic [7:0] m_tx = 0, m_cmd = 0, m_sts = 0, m_data = 0;
    bit         m_act = 0, m_wr = 0;
    logic [1:0] m_addr = 0;

    always #2 clk = ~clk;

    ctl_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_rd(wr_rd),
        .din(din), .dout(dout), .dout_en(dout_en), .rx_hold_in(rx_hold_in),
        .status_in(status_in), .tx_hold(tx_hold), .cmd_reg(cmd_reg),
        .mode_regs(mode_regs), .sync_regs(sync_regs), .mr_ptr(mr_ptr),
        .syn_ptr(syn_ptr)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural model: completes an access when chip select is seen high.
    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n) begin
            mptr = 0; sptr = 0; m_act = 0;
            m_mode[0] = 0; m_mode[1] = 0;
            m_syn[0] = 0; m_syn[1] = 0; m_syn[2] = 0;
            m_tx = 0; m_cmd = 0; m_sts = 0;
        end else begin
            m_sts = status_in;
            if (cs_n && m_act) begin
                m_act = 0;
                case ({m_addr, m_wr})
                    3'b001: m_tx = m_data;
                    3'b011: begin m_syn[sptr] = m_data; sptr = (sptr + 1) % 3; end
                    3'b100: mptr = (mptr + 1) % 2;
                    3'b101: begin m_mode[mptr] = m_data; mptr = (mptr + 1) % 2; end
                    3'b110: begin mptr = 0; sptr = 0; end
                    3'b111: m_cmd = m_data;
                    default: ;
                endcase
            end
            if (!cs_n) begin
                m_act = 1; m_addr = addr; m_wr = wr_rd; m_data = din;
            end
        end
    end

    // Compare every output with the model once per cycle.
    always @(negedge clk) begin
        #1;
        if (started && !ended) begin
            check(cs_n ? "R1" : "R2", "dout_en", 32'(dout_en), 32'(!cs_n && !wr_rd));
            if (!cs_n && !wr_rd) begin
                case (addr)
                    2'd0: check("R2", "dout rx", 32'(dout), 32'(rx_hold_in));
                    2'd1: check("R8", "dout status", 32'(dout), 32'(m_sts));
                    2'd2: check("R4", "dout mode", 32'(dout), 32'(m_mode[mptr]));
                    default: check("R2", "dout cmd", 32'(dout), 32'(m_cmd));
                endcase
            end
            check("R3", "tx_hold", 32'(tx_hold), 32'(m_tx));
            check("R3", "cmd_reg", 32'(cmd_reg), 32'(m_cmd));
            check("R4", "mode_regs", 32'(mode_regs), 32'({m_mode[1], m_mode[0]}));
            check("R5", "sync_regs", 32'(sync_regs), 32'({m_syn[2], m_syn[1], m_syn[0]}));
            check("R6", "mr_ptr", 32'(mr_ptr), 32'(mptr));
            check("R6", "syn_ptr", 32'(syn_ptr), 32'(sptr));
        end
    end

    // Datapath inputs change every cycle.
    always @(negedge clk) begin
        rx_hold_in <= rx_hold_in + 8'd7;
        status_in  <= status_in ^ 8'h5b ^ 8'(cyc);
    end

    task automatic access(input logic [1:0] a, input logic w, input logic [7:0] d, input int hold);
        @(negedge clk);
        cs_n = 1'b0; addr = a; wr_rd = w; din = d;
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            din = d ^ 8'(i);
        end
        if (hold > 1) begin
            @(negedge clk);
            din = d;
        end
        @(negedge clk);
        cs_n = 1'b1; wr_rd = 1'b0; din = 8'h00;
    endtask

    task automatic settle;
        @(negedge clk); #2;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle();
        check("R7", "mode after reset", 32'(mode_regs), 32'h0);
        check("R7", "ptrs after reset", 32'({mr_ptr, syn_ptr}), 32'h0);
        // Mode writes then reads: R4.
        access(2'd2, 1'b1, 8'hA5, 1);
        access(2'd2, 1'b1, 8'h3C, 1);
        access(2'd2, 1'b0, 8'h00, 1);
        access(2'd2, 1'b0, 8'h00, 2);
        settle();
        check("R4", "mode pair", 32'(mode_regs), 32'h3CA5);
        // Sync writes with recycle: R5.
        access(2'd1, 1'b1, 8'h16, 1);
        access(2'd1, 1'b1, 8'h17, 1);
        access(2'd1, 1'b1, 8'h10, 1);
        access(2'd1, 1'b1, 8'h99, 1);
        settle();
        check("R5", "sync recycle", 32'(sync_regs), 32'h101799);
        check("R5", "syn_ptr after four", 32'(syn_ptr), 32'd1);
        // Status and rx reads leave pointers: R8, R2.
        access(2'd1, 1'b0, 8'h00, 1);
        access(2'd0, 1'b0, 8'h00, 3);
        settle();
        check("R5", "syn_ptr after status read", 32'(syn_ptr), 32'd1);
        // Command write does not clear, command read does: R3, R6.
        access(2'd2, 1'b1, 8'h11, 1);
        access(2'd3, 1'b1, 8'hC3, 1);
        settle();
        check("R6", "mr_ptr after cmd write", 32'(mr_ptr), 32'd1);
        check("R3", "cmd_reg", 32'(cmd_reg), 32'hC3);
        access(2'd3, 1'b0, 8'h00, 1);
        settle();
        check("R6", "ptrs after cmd read", 32'({mr_ptr, syn_ptr}), 32'h0);
        access(2'd2, 1'b1, 8'h22, 1);
        access(2'd0, 1'b1, 8'h5E, 1);
        settle();
        check("R6", "mode after clear", 32'(mode_regs[7:0]), 32'h22);
        check("R3", "tx_hold", 32'(tx_hold), 32'h5E);
        // Long access steps once: R9.
        access(2'd2, 1'b1, 8'h77, 6);
        settle();
        check("R9", "mr_ptr after long write", 32'(mr_ptr), 32'd0);
        check("R9", "mode2 long write", 32'(mode_regs[15:8]), 32'h77);
        access(2'd1, 1'b1, 8'h44, 5);
        settle();
        check("R9", "syn_ptr after long write", 32'(syn_ptr), 32'd1);
        // Interleaved mode read and write: R4.
        access(2'd2, 1'b0, 8'h00, 1);
        access(2'd2, 1'b1, 8'h88, 1);
        access(2'd2, 1'b0, 8'h00, 1);
        settle();
        check("R4", "interleave", 32'(mode_regs), 32'h8822);
        // Mid-run reset: R7.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2;
        check("R7", "all cleared", 32'(mode_regs | 16'(cmd_reg) | 16'(tx_hold)), 32'h0);
        check("R7", "sync cleared", 32'(sync_regs), 32'h0);
        repeat (4) @(negedge clk);
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule